// File: doc/BRIEF.md
# Ordered register-pair load unit

This unit runs one acquire-style paired load from a 32-bit instruction word. It checks that the word carries the fixed opcode pattern of the pair load and pulls out the element size, the addressing form and three register indices. It then reads memory once, with a request twice the element width. When the response returns, the unit splits the data into two register values and writes them through a single register-file write port. The first destination is always written before the second. If the form asks for it, a third write stores the advanced base address.

The caller presents the instruction together with the value of the base register. When the base index is 31, that value is the stack pointer. The caller also supplies a big-endian data flag. The unit captures all three when it accepts the instruction and ignores further strobes until it finishes. Some encodings have awkward register overlaps, and the way these resolve is fixed at elaboration time by two policy parameters. The value the unit writes as an "unknown" result is a constant parameter, so the outcome can be predicted. Each instruction ends with a one-cycle completion pulse. Three flags are valid with that pulse: undefined, no-op and alignment fault.

Top module: `pairload_unit`

## Requirements
- R1: The word is accepted as the pair load only when bit 31 = 1, bits 29:24 = 011001, bits 23:22 = 01, bit 21 = 0, bits 15:13 = 000 and bits 11:10 = 10. Any other word completes with the undefined flag set, with no memory request and no register write.
- R2: The fields are: bit 30 = element width (0: 32-bit, 1: 64-bit), bits 20:16 = second destination, bit 12 = addressing form, bits 9:5 = base index, bits 4:0 = first destination. `mem_req_wide` is 1 for a 128-bit read and 0 for a 64-bit read.
- R3: An executed instruction raises exactly one single-cycle memory request. Its address is the captured base value, unmodified. The unit waits as long as needed for `mem_resp_valid`.
- R4: When `big_endian` is 0, the lower half of the returned pair goes to the first destination and the upper half to the second. When it is 1, the two are swapped. For 32-bit elements only `mem_resp_data[63:0]` is used.
- R5: A 32-bit element is written zero-extended to 64 bits.
- R6: The register writes come on consecutive cycles in this order: first destination, then second destination, then the base writeback if there is one.
- R7: Bit 12 = 0 selects writeback. Base index n receives base+8 for 32-bit elements or base+16 for 64-bit elements, and `rf_wsp` is 1 exactly when n = 31. Bit 12 = 1 gives no writeback.
- R8: The overlap case is writeback selected, a destination equal to the base index, and base index not 31. In that case `WBO_POL` applies: 0 skips the writeback, 1 writes `UNK_VALUE` as the base, 2 completes as undefined, and 3 completes as a no-op with no request or writes.
- R9: When the two destination indices are equal, `DUP_POL` applies, evaluated after R8: 0 writes `UNK_VALUE` (its low 32 bits zero-extended for 32-bit elements) to both destinations, 1 completes as undefined, and 2 completes as a no-op.
- R10: When the base index is 31 and the base value is not a multiple of `SP_ALIGN_BYTES` (16), the instruction completes with the alignment-fault flag, with no request and no register writes. A base index other than 31 is never checked.
- R11: Completion is a one-cycle `done_valid` pulse with the three flags valid. `busy` is high from acceptance to completion, and `insn_valid` is ignored while `busy` is high.
- R12: After reset, `busy`, `mem_req_valid`, `rf_we` and `done_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| insn_valid | input | 1 | Instruction strobe, honoured while idle |
| insn | input | 32 | Instruction word |
| base_val | input | 64 | Base register value, or the stack pointer when the base index is 31 |
| big_endian | input | 1 | Big-endian data arrangement |
| busy | output | 1 | Instruction in progress |
| mem_req_valid | output | 1 | Single-cycle read request |
| mem_req_addr | output | 64 | Read address |
| mem_req_wide | output | 1 | 1: 128-bit read, 0: 64-bit read |
| mem_resp_valid | input | 1 | Read data valid |
| mem_resp_data | input | 128 | Read data |
| rf_we | output | 1 | Register-file write enable |
| rf_waddr | output | 5 | Register index written |
| rf_wsp | output | 1 | Write targets the stack pointer |
| rf_wdata | output | 64 | Register write data |
| done_valid | output | 1 | Completion pulse |
| undef_flag | output | 1 | Undefined encoding, valid with done |
| nop_flag | output | 1 | Completed as no-op, valid with done |
| align_fault | output | 1 | Stack-pointer alignment fault, valid with done |

## Verification
The assertions assume the memory side returns exactly one response per request, and only while the unit is waiting for it. They also assume the base value and the endian flag matter only in the cycle the instruction is accepted. The stimulus drives a single response pulse for each request it observes, after a latency of 0 to 3 cycles, and never drives a response when no request is outstanding. It does raise `insn_valid` with an unrelated word while the unit is busy, which checks that this strobe is ignored. Four instances with different policy pairs receive the same sweep of sizes, addressing forms, endian settings, overlap patterns, stack-pointer alignments and single-bit opcode corruptions.

// File: rtl/pairload_pkg.sv
package pairload_pkg;

  localparam int REG_IDX_W = 5;
  localparam logic [REG_IDX_W-1:0] SP_INDEX = 5'd31;

  typedef enum logic [1:0] {
    WBO_SUPPRESS = 2'd0,
    WBO_UNKNOWN  = 2'd1,
    WBO_UNDEF    = 2'd2,
    WBO_NOP      = 2'd3
  } wbo_policy_e;

  typedef enum logic [1:0] {
    DUP_UNKNOWN = 2'd0,
    DUP_UNDEF   = 2'd1,
    DUP_NOP     = 2'd2
  } dup_policy_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT_RESP,
    ST_WRITE1,
    ST_WRITE2,
    ST_WRITEBACK,
    ST_DONE
  } seq_state_e;

  typedef struct packed {
    logic                 wide;
    logic                 wback;
    logic [REG_IDX_W-1:0] rt1;
    logic [REG_IDX_W-1:0] rt2;
    logic [REG_IDX_W-1:0] rbase;
  } pair_fields_t;

  typedef struct packed {
    logic undef;
    logic nop;
    logic wb_skip;
    logic wb_unk;
    logic rt_unk;
  } pair_action_t;

endpackage

// File: rtl/pairload_decode.sv
module pairload_decode
  import pairload_pkg::*;
#(
  parameter wbo_policy_e WBO_POL = WBO_SUPPRESS,
  parameter dup_policy_e DUP_POL = DUP_UNKNOWN
) (
  input  logic [31:0]  insn,
  output pair_fields_t fld,
  output pair_action_t act
);

  logic hit;
  logic base_clash;

  always_comb begin
    hit = insn[31] && (insn[29:24] == 6'b011001) && (insn[23:22] == 2'b01)
          && !insn[21] && (insn[15:13] == 3'b000) && (insn[11:10] == 2'b10);
    fld.wide  = insn[30];
    fld.wback = !insn[12];
    fld.rt2   = insn[20:16];
    fld.rbase = insn[9:5];
    fld.rt1   = insn[4:0];
  end

  assign base_clash = fld.wback && (fld.rt1 == fld.rbase || fld.rt2 == fld.rbase)
                      && (fld.rbase != SP_INDEX);

  always_comb begin
    act = '0;
    if (!hit) begin
      act.undef = 1'b1;
    end else begin
      if (base_clash) begin
        case (WBO_POL)
          WBO_SUPPRESS: act.wb_skip = 1'b1;
          WBO_UNKNOWN:  act.wb_unk  = 1'b1;
          WBO_UNDEF:    act.undef   = 1'b1;
          default:      act.nop     = 1'b1;
        endcase
      end
      if (!act.undef && !act.nop && fld.rt1 == fld.rt2) begin
        case (DUP_POL)
          DUP_UNKNOWN: act.rt_unk = 1'b1;
          DUP_UNDEF:   act.undef  = 1'b1;
          default:     act.nop    = 1'b1;
        endcase
      end
    end
  end

  always_comb begin
    assert_excl_outcome_R8: assert (!(act.undef && act.nop));
    assert_wb_choice_R8: assert (!(act.wb_skip && act.wb_unk));
  end

endmodule

// File: rtl/pairload_split.sv
module pairload_split #(
  parameter int          XLEN      = 64,
  parameter logic [63:0] UNK_VALUE = 64'hA5A5_5A5A_C3C3_3C3C
) (
  input  logic              wide,
  input  logic              big_endian,
  input  logic              rt_unk,
  input  logic [2*XLEN-1:0] data,
  output logic [XLEN-1:0]   first_val,
  output logic [XLEN-1:0]   second_val
);

  localparam int HALF = XLEN / 2;

  logic [XLEN-1:0] lo_elem;
  logic [XLEN-1:0] hi_elem;
  logic [XLEN-1:0] unk_elem;

  always_comb begin
    if (wide) begin
      lo_elem  = data[XLEN-1:0];
      hi_elem  = data[2*XLEN-1:XLEN];
      unk_elem = UNK_VALUE[XLEN-1:0];
    end else begin
      lo_elem  = {{HALF{1'b0}}, data[HALF-1:0]};
      hi_elem  = {{HALF{1'b0}}, data[XLEN-1:HALF]};
      unk_elem = {{HALF{1'b0}}, UNK_VALUE[HALF-1:0]};
    end
  end

  always_comb begin
    if (rt_unk) begin
      first_val  = unk_elem;
      second_val = unk_elem;
    end else if (big_endian) begin
      first_val  = hi_elem;
      second_val = lo_elem;
    end else begin
      first_val  = lo_elem;
      second_val = hi_elem;
    end
  end

endmodule

// File: rtl/pairload_seq.sv
module pairload_seq
  import pairload_pkg::*;
#(
  parameter int          XLEN           = 64,
  parameter int          SP_ALIGN_BYTES = 16,
  parameter logic [63:0] UNK_VALUE      = 64'hA5A5_5A5A_C3C3_3C3C
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 insn_valid,
  input  logic [31:0]          insn,
  input  logic [XLEN-1:0]      base_val,
  input  logic                 big_endian,
  input  pair_fields_t         fld,
  input  logic                 dec_undef,
  input  logic                 dec_nop,
  input  logic                 wb_skip,
  input  logic                 wb_unk,
  input  logic [XLEN-1:0]      first_val,
  input  logic [XLEN-1:0]      second_val,
  input  logic                 mem_resp_valid,
  input  logic [2*XLEN-1:0]    mem_resp_data,
  output logic [31:0]          insn_q,
  output logic                 be_q,
  output logic [2*XLEN-1:0]    data_q,
  output logic                 busy,
  output logic                 mem_req_valid,
  output logic [XLEN-1:0]      mem_req_addr,
  output logic                 mem_req_wide,
  output logic                 rf_we,
  output logic [REG_IDX_W-1:0] rf_waddr,
  output logic                 rf_wsp,
  output logic [XLEN-1:0]      rf_wdata,
  output logic                 done_valid,
  output logic                 undef_flag,
  output logic                 nop_flag,
  output logic                 align_fault
);

  localparam int              ALIGN_LSB  = $clog2(SP_ALIGN_BYTES);
  localparam logic [XLEN-1:0] OFF_NARROW = XLEN'(XLEN / 8);
  localparam logic [XLEN-1:0] OFF_WIDE   = XLEN'(2 * XLEN / 8);

  seq_state_e      state;
  logic [XLEN-1:0] base_q;
  logic            data_wr_q;
  logic            sp_misaligned;
  logic [XLEN-1:0] next_base;

  assign sp_misaligned = (fld.rbase == SP_INDEX) && (base_q[ALIGN_LSB-1:0] != '0);
  assign next_base     = base_q + (fld.wide ? OFF_WIDE : OFF_NARROW);

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_IDLE;
      insn_q        <= '0;
      base_q        <= '0;
      be_q          <= 1'b0;
      data_q        <= '0;
      busy          <= 1'b0;
      mem_req_valid <= 1'b0;
      mem_req_addr  <= '0;
      mem_req_wide  <= 1'b0;
      rf_we         <= 1'b0;
      rf_waddr      <= '0;
      rf_wsp        <= 1'b0;
      rf_wdata      <= '0;
      data_wr_q     <= 1'b0;
      done_valid    <= 1'b0;
      undef_flag    <= 1'b0;
      nop_flag      <= 1'b0;
      align_fault   <= 1'b0;
    end else begin
      mem_req_valid <= 1'b0;
      rf_we         <= 1'b0;
      rf_wsp        <= 1'b0;
      data_wr_q     <= 1'b0;
      done_valid    <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (insn_valid) begin
            insn_q      <= insn;
            base_q      <= base_val;
            be_q        <= big_endian;
            busy        <= 1'b1;
            undef_flag  <= 1'b0;
            nop_flag    <= 1'b0;
            align_fault <= 1'b0;
            state       <= ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          if (dec_undef) begin
            undef_flag <= 1'b1;
            state      <= ST_DONE;
          end else if (dec_nop) begin
            nop_flag <= 1'b1;
            state    <= ST_DONE;
          end else if (sp_misaligned) begin
            align_fault <= 1'b1;
            state       <= ST_DONE;
          end else begin
            mem_req_valid <= 1'b1;
            mem_req_addr  <= base_q;
            mem_req_wide  <= fld.wide;
            state         <= ST_WAIT_RESP;
          end
        end
        ST_WAIT_RESP: begin
          if (mem_resp_valid) begin
            data_q <= mem_resp_data;
            state  <= ST_WRITE1;
          end
        end
        ST_WRITE1: begin
          rf_we     <= 1'b1;
          rf_waddr  <= fld.rt1;
          rf_wdata  <= first_val;
          data_wr_q <= 1'b1;
          state     <= ST_WRITE2;
        end
        ST_WRITE2: begin
          rf_we     <= 1'b1;
          rf_waddr  <= fld.rt2;
          rf_wdata  <= second_val;
          data_wr_q <= 1'b1;
          state     <= (fld.wback && !wb_skip) ? ST_WRITEBACK : ST_DONE;
        end
        ST_WRITEBACK: begin
          rf_we    <= 1'b1;
          rf_waddr <= fld.rbase;
          rf_wsp   <= (fld.rbase == SP_INDEX);
          rf_wdata <= wb_unk ? UNK_VALUE[XLEN-1:0] : next_base;
          state    <= ST_DONE;
        end
        ST_DONE: begin
          done_valid <= 1'b1;
          busy       <= 1'b0;
          state      <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_single_req_R3: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |=> !mem_req_valid);

  assert_sp_aligned_req_R10: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && fld.rbase == SP_INDEX) |-> (mem_req_addr[ALIGN_LSB-1:0] == '0));

  assert_zero_ext_R5: assert property (@(posedge clk) disable iff (rst)
    (rf_we && data_wr_q && !fld.wide) |-> (rf_wdata[XLEN-1:XLEN/2] == '0));

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    done_valid |=> !done_valid);

  assert_write_while_busy_R11: assert property (@(posedge clk) disable iff (rst)
    rf_we |-> busy);

  assert_reject_silent_R10: assert property (@(posedge clk) disable iff (rst)
    (done_valid && (undef_flag || nop_flag || align_fault)) |-> !$past(rf_we));

endmodule

// File: rtl/pairload_unit.sv
module pairload_unit
  import pairload_pkg::*;
#(
  parameter int          XLEN           = 64,
  parameter int          SP_ALIGN_BYTES = 16,
  parameter wbo_policy_e WBO_POL        = WBO_SUPPRESS,
  parameter dup_policy_e DUP_POL        = DUP_UNKNOWN,
  parameter logic [63:0] UNK_VALUE      = 64'hA5A5_5A5A_C3C3_3C3C
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 insn_valid,
  input  logic [31:0]          insn,
  input  logic [XLEN-1:0]      base_val,
  input  logic                 big_endian,
  output logic                 busy,
  output logic                 mem_req_valid,
  output logic [XLEN-1:0]      mem_req_addr,
  output logic                 mem_req_wide,
  input  logic                 mem_resp_valid,
  input  logic [2*XLEN-1:0]    mem_resp_data,
  output logic                 rf_we,
  output logic [REG_IDX_W-1:0] rf_waddr,
  output logic                 rf_wsp,
  output logic [XLEN-1:0]      rf_wdata,
  output logic                 done_valid,
  output logic                 undef_flag,
  output logic                 nop_flag,
  output logic                 align_fault
);

  logic [31:0]       insn_q;
  logic              be_q;
  logic [2*XLEN-1:0] data_q;
  pair_fields_t      fld;
  pair_action_t      act;
  logic [XLEN-1:0]   first_val;
  logic [XLEN-1:0]   second_val;

  pairload_decode #(
    .WBO_POL (WBO_POL),
    .DUP_POL (DUP_POL)
  ) u_decode (
    .insn (insn_q),
    .fld  (fld),
    .act  (act)
  );

  pairload_split #(
    .XLEN      (XLEN),
    .UNK_VALUE (UNK_VALUE)
  ) u_split (
    .wide       (fld.wide),
    .big_endian (be_q),
    .rt_unk     (act.rt_unk),
    .data       (data_q),
    .first_val  (first_val),
    .second_val (second_val)
  );

  pairload_seq #(
    .XLEN           (XLEN),
    .SP_ALIGN_BYTES (SP_ALIGN_BYTES),
    .UNK_VALUE      (UNK_VALUE)
  ) u_seq (
    .clk            (clk),
    .rst            (rst),
    .insn_valid     (insn_valid),
    .insn           (insn),
    .base_val       (base_val),
    .big_endian     (big_endian),
    .fld            (fld),
    .dec_undef      (act.undef),
    .dec_nop        (act.nop),
    .wb_skip        (act.wb_skip),
    .wb_unk         (act.wb_unk),
    .first_val      (first_val),
    .second_val     (second_val),
    .mem_resp_valid (mem_resp_valid),
    .mem_resp_data  (mem_resp_data),
    .insn_q         (insn_q),
    .be_q           (be_q),
    .data_q         (data_q),
    .busy           (busy),
    .mem_req_valid  (mem_req_valid),
    .mem_req_addr   (mem_req_addr),
    .mem_req_wide   (mem_req_wide),
    .rf_we          (rf_we),
    .rf_waddr       (rf_waddr),
    .rf_wsp         (rf_wsp),
    .rf_wdata       (rf_wdata),
    .done_valid     (done_valid),
    .undef_flag     (undef_flag),
    .nop_flag       (nop_flag),
    .align_fault    (align_fault)
  );

endmodule

// File: tb/pairload_unit_tb.sv
module pairload_unit_tb;
  import pairload_pkg::*;

  localparam int          NI  = 4;
  localparam logic [63:0] UNK = 64'hA5A5_5A5A_C3C3_3C3C;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic         insn_valid = 1'b0;
  logic [31:0]  insn = '0;
  logic [63:0]  base_val = '0;
  logic         big_endian = 1'b0;
  logic         mem_resp_valid = 1'b0;
  logic [127:0] mem_resp_data = '0;

  logic        o_busy [NI];
  logic        o_req  [NI];
  logic [63:0] o_addr [NI];
  logic        o_wide [NI];
  logic        o_we   [NI];
  logic [4:0]  o_waddr[NI];
  logic        o_wsp  [NI];
  logic [63:0] o_wdata[NI];
  logic        o_done [NI];
  logic        o_undef[NI];
  logic        o_nop  [NI];
  logic        o_fault[NI];

  pairload_unit #(
    .WBO_POL (WBO_SUPPRESS),
    .DUP_POL (DUP_UNKNOWN),
    .UNK_VALUE (UNK)
  ) u_dut (
    .clk (clk), .rst (rst), .insn_valid (insn_valid), .insn (insn),
    .base_val (base_val), .big_endian (big_endian), .busy (o_busy[0]),
    .mem_req_valid (o_req[0]), .mem_req_addr (o_addr[0]), .mem_req_wide (o_wide[0]),
    .mem_resp_valid (mem_resp_valid), .mem_resp_data (mem_resp_data),
    .rf_we (o_we[0]), .rf_waddr (o_waddr[0]), .rf_wsp (o_wsp[0]), .rf_wdata (o_wdata[0]),
    .done_valid (o_done[0]), .undef_flag (o_undef[0]), .nop_flag (o_nop[0]),
    .align_fault (o_fault[0])
  );

  for (genvar g = 1; g < NI; g++) begin : g_alt
    localparam logic [1:0] WP = 2'(g);
    localparam logic [1:0] DP = 2'(g % 3);
    pairload_unit #(
      .WBO_POL (wbo_policy_e'(WP)),
      .DUP_POL (dup_policy_e'(DP)),
      .UNK_VALUE (UNK)
    ) u_alt (
      .clk (clk), .rst (rst), .insn_valid (insn_valid), .insn (insn),
      .base_val (base_val), .big_endian (big_endian), .busy (o_busy[g]),
      .mem_req_valid (o_req[g]), .mem_req_addr (o_addr[g]), .mem_req_wide (o_wide[g]),
      .mem_resp_valid (mem_resp_valid), .mem_resp_data (mem_resp_data),
      .rf_we (o_we[g]), .rf_waddr (o_waddr[g]), .rf_wsp (o_wsp[g]), .rf_wdata (o_wdata[g]),
      .done_valid (o_done[g]), .undef_flag (o_undef[g]), .nop_flag (o_nop[g]),
      .align_fault (o_fault[g])
    );
  end

  int nvec = 0;
  int nmis = 0;

  logic        mon_en = 1'b0;
  int          rec_cnt [NI];
  logic [63:0] rec_data[NI][4];
  logic [4:0]  rec_addr[NI][4];
  logic        rec_sp  [NI][4];
  int          req_cnt [NI];
  logic [63:0] req_addr[NI];
  logic        req_wide[NI];
  int          done_cnt[NI];
  logic        f_undef [NI];
  logic        f_nop   [NI];
  logic        f_fault [NI];

  always @(negedge clk) begin
    if (mon_en) begin
      for (int i = 0; i < NI; i++) begin
        if (o_we[i]) begin
          if (rec_cnt[i] < 4) begin
            rec_data[i][rec_cnt[i]] = o_wdata[i];
            rec_addr[i][rec_cnt[i]] = o_waddr[i];
            rec_sp[i][rec_cnt[i]]   = o_wsp[i];
          end
          rec_cnt[i]++;
        end
        if (o_req[i]) begin
          req_cnt[i]++;
          req_addr[i] = o_addr[i];
          req_wide[i] = o_wide[i];
        end
        if (o_done[i]) begin
          done_cnt[i]++;
          f_undef[i] = o_undef[i];
          f_nop[i]   = o_nop[i];
          f_fault[i] = o_fault[i];
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nvec++;
    if (!ok) begin
      nmis++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input bit wide, input bit wb, input logic [4:0] t2,
                                     input logic [4:0] n, input logic [4:0] t);
    return {1'b1, wide, 6'b011001, 2'b01, 1'b0, t2, 3'b000, !wb, 2'b10, n, t};
  endfunction

  task automatic run_vec(input logic [31:0] ins, input logic [63:0] base, input bit be,
                         input logic [127:0] data, input int lat, input string ctag);
    int wc;
    bit all_done;
    for (int i = 0; i < NI; i++) begin
      rec_cnt[i] = 0; req_cnt[i] = 0; done_cnt[i] = 0;
    end
    @(negedge clk);
    insn = ins; base_val = base; big_endian = be; insn_valid = 1'b1;
    @(negedge clk);
    insn = ~ins;
    base_val = ~base;
    big_endian = !be;
    wc = -1;
    for (int c = 0; c < 60; c++) begin
      @(negedge clk);
      insn_valid = 1'b0;
      mem_resp_valid = 1'b0;
      if (wc == 0) begin
        mem_resp_valid = 1'b1; mem_resp_data = data; wc = -2;
      end else if (wc > 0) begin
        wc--;
      end else if (wc == -1 && (o_req[0] || o_req[1] || o_req[2] || o_req[3])) begin
        if (lat == 0) begin
          mem_resp_valid = 1'b1; mem_resp_data = data; wc = -2;
        end else wc = lat - 1;
      end
      all_done = 1'b1;
      for (int i = 0; i < NI; i++) if (done_cnt[i] == 0) all_done = 1'b0;
      if (all_done) break;
    end
    @(negedge clk);
    mem_resp_valid = 1'b0;

    for (int i = 0; i < NI; i++) begin
      automatic int wp = i;
      automatic int dp = i % 3;
      automatic bit hit = ins[31] && ins[29:24] == 6'b011001 && ins[23:22] == 2'b01 &&
                          !ins[21] && ins[15:13] == 3'b000 && ins[11:10] == 2'b10;
      automatic bit wide = ins[30];
      automatic bit wb = !ins[12];
      automatic logic [4:0] t = ins[4:0];
      automatic logic [4:0] t2 = ins[20:16];
      automatic logic [4:0] n = ins[9:5];
      automatic bit eu = 0, en = 0, ef = 0, wsup = 0, wunk = 0, runk = 0, ereq;
      automatic int ecnt;
      automatic logic [63:0] lo, hi, d1, d2, wbv;
      automatic logic [63:0] ed[3];
      automatic logic [4:0]  ea[3];
      automatic string dtag;
      if (!hit) eu = 1;
      else begin
        if (wb && (t == n || t2 == n) && n != 5'd31) begin
          case (wp)
            0: wsup = 1;
            1: wunk = 1;
            2: eu = 1;
            default: en = 1;
          endcase
        end
        if (!eu && !en && t == t2) begin
          case (dp)
            0: runk = 1;
            1: eu = 1;
            default: en = 1;
          endcase
        end
        if (!eu && !en && n == 5'd31 && base[3:0] != 4'd0) ef = 1;
      end
      ereq = !(eu || en || ef);
      lo = wide ? data[63:0]   : {32'd0, data[31:0]};
      hi = wide ? data[127:64] : {32'd0, data[63:32]};
      d1 = be ? hi : lo;
      d2 = be ? lo : hi;
      if (runk) begin
        d1 = wide ? UNK : {32'd0, UNK[31:0]};
        d2 = d1;
      end
      wbv = wunk ? UNK : base + (wide ? 64'd16 : 64'd8);
      ecnt = ereq ? (2 + ((wb && !wsup) ? 1 : 0)) : 0;
      ed[0] = d1; ed[1] = d2; ed[2] = wbv;
      ea[0] = t;  ea[1] = t2; ea[2] = n;
      dtag = runk ? "R9" : (!wide ? "R5" : "R4");

      chk(done_cnt[i] == 1, "R11", $sformatf("inst%0d done pulses", i), 64'(done_cnt[i]), 64'd1);
      chk(f_undef[i] == eu, ctag, $sformatf("inst%0d undef", i), 64'(f_undef[i]), 64'(eu));
      chk(f_nop[i] == en, ctag, $sformatf("inst%0d nop", i), 64'(f_nop[i]), 64'(en));
      chk(f_fault[i] == ef, "R10", $sformatf("inst%0d fault", i), 64'(f_fault[i]), 64'(ef));
      chk(req_cnt[i] == (ereq ? 1 : 0), "R3", $sformatf("inst%0d requests", i),
          64'(req_cnt[i]), 64'(ereq));
      if (ereq && req_cnt[i] == 1) begin
        chk(req_addr[i] == base, "R3", $sformatf("inst%0d req addr", i), req_addr[i], base);
        chk(req_wide[i] == wide, "R2", $sformatf("inst%0d req wide", i),
            64'(req_wide[i]), 64'(wide));
      end
      chk(rec_cnt[i] == ecnt, "R6", $sformatf("inst%0d write count", i),
          64'(rec_cnt[i]), 64'(ecnt));
      for (int k = 0; k < 3; k++) begin
        if (k < ecnt && k < rec_cnt[i]) begin
          chk(rec_addr[i][k] == ea[k], "R6", $sformatf("inst%0d write%0d index", i, k),
              64'(rec_addr[i][k]), 64'(ea[k]));
          chk(rec_data[i][k] == ed[k], (k == 2) ? (wunk ? "R8" : "R7") : dtag,
              $sformatf("inst%0d write%0d data", i, k), rec_data[i][k], ed[k]);
          chk(rec_sp[i][k] == (k == 2 && n == 5'd31), "R7",
              $sformatf("inst%0d write%0d sp", i, k), 64'(rec_sp[i][k]),
              64'(k == 2 && n == 5'd31));
        end
      end
    end
  endtask

  initial begin
    #(4 * 150000);
    nmis++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nmis);
    $finish;
  end

  initial begin
    int v;
    repeat (3) @(posedge clk);
    @(negedge clk);
    for (int i = 0; i < NI; i++) begin
      chk(!o_busy[i] && !o_req[i] && !o_we[i] && !o_done[i], "R12",
          $sformatf("inst%0d reset outputs", i),
          {60'd0, o_busy[i], o_req[i], o_we[i], o_done[i]}, 64'd0);
    end
    rst = 1'b0;
    mon_en = 1'b1;
    v = 0;
    for (int wide = 0; wide < 2; wide++)
      for (int wb = 0; wb < 2; wb++)
        for (int be = 0; be < 2; be++)
          for (int sc = 0; sc < 7; sc++) begin
            logic [4:0] t, t2, n;
            logic [63:0] base;
            logic [127:0] data;
            string ctag;
            t = 5'd3; t2 = 5'd7; n = 5'd12;
            base = 64'h4000_0000 + 64'(v) * 64'h28;
            ctag = "R1";
            case (sc)
              1: begin t = 5'd12; ctag = "R8"; end
              2: begin t2 = 5'd12; ctag = "R8"; end
              3: begin t2 = 5'd3; ctag = "R9"; end
              4: begin n = 5'd31; base = 64'h8000_1000 + 64'(v) * 64'h10; ctag = "R10"; end
              5: begin n = 5'd31; base = 64'h8000_1004 + 64'(v) * 64'h4; ctag = "R10"; end
              6: begin t = 5'd12; t2 = 5'd12; ctag = "R8"; end
              default: ;
            endcase
            if (sc == 5 && base[3:0] == 4'd0) base = base + 64'd8;
            data = {64'(v + 1) * 64'h9E37_79B9_7F4A_7C15, ~(64'(v + 3) * 64'hC2B2_AE3D_27D4_EB4F)};
            run_vec(mk(wide[0], wb[0], t2, n, t), base, be[0], data, v % 4, ctag);
            v++;
          end
    begin
      logic [31:0] good;
      logic [31:0] flips [15];
      good = mk(1'b1, 1'b1, 5'd4, 5'd9, 5'd2);
      flips = '{31, 29, 28, 27, 26, 25, 24, 23, 22, 21, 15, 14, 13, 11, 10};
      for (int b = 0; b < 15; b++) begin
        run_vec(good ^ (32'd1 << flips[b]), 64'h5000_0000 + 64'(b) * 64'h10, b[0],
                {64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888}, b % 4, "R1");
      end
    end
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nmis);
    $finish;
  end

endmodule